// File: doc/BRIEF.md
# GPIO Port Controller with Latched Outputs

This block controls a bank of general-purpose pins from a simple single-cycle register bus. Each pin can serve as a software-controlled I/O or hand its pad to one of three peripheral functions. A per-pin 2-bit function field makes that choice. In I/O mode, a direction bit enables the pad driver and an output latch supplies the driven level. Software can load the latch with a whole word, or it can change single bits through set, clear and toggle strobes. A write may combine these strobes in one access.

Pad levels pass through a two-flop synchronizer before anything reads them. The bus read path, the wake-up logic and the interrupt logic all use these synchronized levels. The block has three edge-interrupt channels. Each channel watches one chosen pin and emits a single-cycle pulse on a rising or falling edge. A wake mask marks the pins whose high level raises a wake request. Changes to the function fields reach the pads two clock cycles after the write.

The bus is a write strobe with an address and data, plus a combinational read of the same address. The address is `{region[3:0], index[1:0]}`. Region 0 is the data word, 1 is direction, 2 is the wake mask, 3 is the function fields and 4 is the interrupt configuration. Regions 8 to 15 are latch operations. The index selects the word or the interrupt channel. Unmapped reads return 0.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every pin is in I/O mode as an input: pin_oe is all 0, pin_out is all 0, xint and wake_req are 0, and the latch (region 8), direction (region 1) and function (region 3) words all read 0.
- R2: A read of region 0, word w, returns the synchronized levels of pins 32w to 32w+31, whatever their direction. A pad change made before clock edge E shows at the read port after edge E+1, not after edge E.
- R3: A write to region 0, word w, loads the whole latch word w, and a read of any region from 8 to 15 returns that latch word.
- R4: A write to region 8+k applies the data as a mask. Bit 0 of k means set, bit 1 means clear and bit 2 means toggle. Only latch bits where the data is 1 change, and region 8 changes nothing.
- R5: When several operations hit one bit in the same write, clear beats set and set beats toggle.
- R6: Direction bit 1 makes the pin an output. In I/O mode pin_oe equals the direction bit and pin_out equals the latch. The latch keeps its value while the pin is an input, so switching the pin to output drives the value already loaded. Direction writes take effect at the write edge.
- R7: Pin p's 2-bit function field sits in region 3, word p/16, bits 2*(p%16)+1:2*(p%16). Value 0 selects I/O mode. Value k from 1 to 3 routes per_out and per_oe bit (k-1)*64+p to the pad.
- R8: A function-field write reads back right after the write edge. The pads keep the old routing after the write edge and after the next edge, and use the new routing from the second edge after the write edge.
- R9: Interrupt channel c (region 4, index c) takes its source pin number in bits 5:0 and its polarity in bit 8, where 1 means rising and 0 means falling. xint[c] is high for exactly one cycle. The pulse starts after the edge at which the synchronized source level changes, which is the second edge after the pad changes.
- R10: Writing a channel's configuration raises no pulse merely because the newly selected pin has a different level from the old one.
- R11: wake_req is high exactly while some pin with its wake-mask bit (region 2) set has a synchronized level of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address {region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 64 | Pad input levels (asynchronous) |
| pin_out | output | 64 | Pad output levels |
| pin_oe | output | 64 | Pad output enables |
| per_out | input | 192 | Peripheral output levels, function k at bits (k-1)*64+p |
| per_oe | input | 192 | Peripheral output enables, same layout |
| xint | output | 3 | One-cycle edge interrupt pulses |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench sends combined latch operations to bits whose start value makes each wrong priority visible. A design that lets toggle act before set would flip bits that are already 1. A design that lets set beat clear would leave bits at 1 that should be 0.

The bench samples the pads after each of the two edges that follow a function-field write. Routing that switches one edge early or late fails one of these samples. The bench reads a pad change after one edge and again after two edges, which catches a synchronizer that is too short or too long.

For interrupts, the bench reselects a channel onto a pin that is already high and checks that no pulse appears. It also toggles a pin against the wrong polarity, which catches a channel that fires on both edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_W   = 4;
  localparam int IDX_W   = 2;
  localparam int ADDR_W  = REG_W + IDX_W;
  localparam int POL_BIT = 8;

  localparam logic [REG_W-1:0] RG_DATA = 4'd0;
  localparam logic [REG_W-1:0] RG_DIR  = 4'd1;
  localparam logic [REG_W-1:0] RG_WAKE = 4'd2;
  localparam logic [REG_W-1:0] RG_MUX  = 4'd3;
  localparam logic [REG_W-1:0] RG_XINT = 4'd4;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_ALT1 = 2'd1,
    FN_ALT2 = 2'd2,
    FN_ALT3 = 2'd3
  } pin_fn_e;

  // Per-bit latch update: clear beats set, set beats toggle.
  function automatic logic latch_bit(input logic q, input logic s,
                                     input logic c, input logic t);
    if (c) return 1'b0;
    if (s) return 1'b1;
    if (t) return ~q;
    return q;
  endfunction

  // Pad source selection for one pin.
  function automatic logic fn_pick(input logic [1:0] fn, input logic g,
                                   input logic a1, input logic a2, input logic a3);
    case (pin_fn_e'(fn))
      FN_GPIO: return g;
      FN_ALT1: return a1;
      FN_ALT2: return a2;
      default: return a3;
    endcase
  endfunction

  // Qualifying edge: pol=1 rising, pol=0 falling.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q
);

  logic [NPINS-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      sync_q   <= stage1_q;
    end
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 64,
  parameter int CFG_DLY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   ld_m,
  input  logic [NPINS-1:0]   ld_v,
  input  logic [NPINS-1:0]   set_m,
  input  logic [NPINS-1:0]   clr_m,
  input  logic [NPINS-1:0]   tgl_m,
  input  logic [NPINS-1:0]   dir_m,
  input  logic [NPINS-1:0]   dir_v,
  input  logic [NPINS-1:0]   wake_m,
  input  logic [NPINS-1:0]   wake_v,
  input  logic [2*NPINS-1:0] mux_m,
  input  logic [2*NPINS-1:0] mux_v,
  input  logic [3*NPINS-1:0] per_out,
  input  logic [3*NPINS-1:0] per_oe,
  output logic [NPINS-1:0]   latch_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   wake_q,
  output logic [2*NPINS-1:0] mux_q,
  output logic [2*NPINS-1:0] mux_live,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);

  localparam int MUX_W = 2 * NPINS;

  logic [MUX_W-1:0] mux_pipe [CFG_DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      wake_q  <= '0;
      mux_q   <= '0;
    end else begin
      for (int p = 0; p < NPINS; p++) begin
        latch_q[p] <= ld_m[p] ? ld_v[p]
                              : latch_bit(latch_q[p], set_m[p], clr_m[p], tgl_m[p]);
      end
      dir_q  <= (dir_q  & ~dir_m)  | (dir_v  & dir_m);
      wake_q <= (wake_q & ~wake_m) | (wake_v & wake_m);
      mux_q  <= (mux_q  & ~mux_m)  | (mux_v  & mux_m);
    end
  end

  // Configuration delay line: routing follows the written value CFG_DLY edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_DLY; i++) mux_pipe[i] <= '0;
    end else begin
      mux_pipe[0] <= mux_q;
      for (int i = 1; i < CFG_DLY; i++) mux_pipe[i] <= mux_pipe[i-1];
    end
  end

  assign mux_live = mux_pipe[CFG_DLY-1];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] fn;
    assign fn = mux_live[2*p +: 2];
    assign pin_out[p] = fn_pick(fn, latch_q[p], per_out[p],
                                per_out[NPINS+p], per_out[2*NPINS+p]);
    assign pin_oe[p]  = fn_pick(fn, dir_q[p], per_oe[p],
                                per_oe[NPINS+p], per_oe[2*NPINS+p]);
  end

endmodule

// File: rtl/gpio_xint.sv
module gpio_xint
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 64,
  parameter int NXINT = 3,
  parameter int SELW  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NXINT-1:0]      cfg_we,
  input  logic [SELW-1:0]       sel_w,
  input  logic                  pol_w,
  input  logic [NPINS-1:0]      lvl,
  output logic [NXINT*SELW-1:0] cfg_sel,
  output logic [NXINT-1:0]      cfg_pol,
  output logic [NXINT-1:0]      src_lvl,
  output logic [NXINT-1:0]      xint
);

  for (genvar c = 0; c < NXINT; c++) begin : g_ch
    logic [SELW-1:0] sel_r;
    logic            pol_r;
    logic            prev_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_r  <= '0;
        pol_r  <= 1'b0;
        prev_r <= 1'b0;
      end else if (cfg_we[c]) begin
        sel_r  <= sel_w;
        pol_r  <= pol_w;
        prev_r <= lvl[sel_w];   // history follows the new source
      end else begin
        prev_r <= src_lvl[c];
      end
    end

    assign src_lvl[c]              = lvl[sel_r];
    assign xint[c]                 = edge_hit(src_lvl[c], prev_r, pol_r);
    assign cfg_sel[c*SELW +: SELW] = sel_r;
    assign cfg_pol[c]              = pol_r;
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 64,
  parameter int DW      = 32,
  parameter int NXINT   = 3,
  parameter int CFG_DLY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  input  logic [3*NPINS-1:0] per_out,
  input  logic [3*NPINS-1:0] per_oe,
  output logic [NXINT-1:0]   xint,
  output logic               wake_req
);

  localparam int NWORD = NPINS / DW;
  localparam int NMUXW = 2 * NPINS / DW;
  localparam int SELW  = $clog2(NPINS);

  logic [REG_W-1:0] region;
  logic [IDX_W-1:0] idx;
  assign region = bus_addr[ADDR_W-1:IDX_W];
  assign idx    = bus_addr[IDX_W-1:0];

  logic [NPINS-1:0]      ld_m, set_m, clr_m, tgl_m, dir_m, wake_m;
  logic [2*NPINS-1:0]    mux_m;
  logic [NXINT-1:0]      xint_we;
  logic [NPINS-1:0]      sync_q, latch_q, dir_q, wake_q;
  logic [2*NPINS-1:0]    mux_q, mux_live;
  logic [NXINT*SELW-1:0] cfg_sel;
  logic [NXINT-1:0]      cfg_pol, src_lvl;

  // Write decode
  always_comb begin
    ld_m = '0; set_m = '0; clr_m = '0; tgl_m = '0;
    dir_m = '0; wake_m = '0; mux_m = '0; xint_we = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (bus_we && idx == IDX_W'(w)) begin
        if (region == RG_DATA) ld_m[w*DW +: DW]   = '1;
        if (region == RG_DIR)  dir_m[w*DW +: DW]  = '1;
        if (region == RG_WAKE) wake_m[w*DW +: DW] = '1;
        if (region[REG_W-1]) begin
          if (region[0]) set_m[w*DW +: DW] = bus_wdata;
          if (region[1]) clr_m[w*DW +: DW] = bus_wdata;
          if (region[2]) tgl_m[w*DW +: DW] = bus_wdata;
        end
      end
    end
    for (int m = 0; m < NMUXW; m++) begin
      if (bus_we && region == RG_MUX && idx == IDX_W'(m)) mux_m[m*DW +: DW] = '1;
    end
    for (int c = 0; c < NXINT; c++) begin
      xint_we[c] = bus_we && region == RG_XINT && idx == IDX_W'(c);
    end
  end

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sync_q (sync_q)
  );

  gpio_pin_bank #(.NPINS(NPINS), .CFG_DLY(CFG_DLY)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_m     (ld_m),
    .ld_v     ({NWORD{bus_wdata}}),
    .set_m    (set_m),
    .clr_m    (clr_m),
    .tgl_m    (tgl_m),
    .dir_m    (dir_m),
    .dir_v    ({NWORD{bus_wdata}}),
    .wake_m   (wake_m),
    .wake_v   ({NWORD{bus_wdata}}),
    .mux_m    (mux_m),
    .mux_v    ({NMUXW{bus_wdata}}),
    .per_out  (per_out),
    .per_oe   (per_oe),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .wake_q   (wake_q),
    .mux_q    (mux_q),
    .mux_live (mux_live),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  gpio_xint #(.NPINS(NPINS), .NXINT(NXINT), .SELW(SELW)) u_xint (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (xint_we),
    .sel_w   (bus_wdata[SELW-1:0]),
    .pol_w   (bus_wdata[POL_BIT]),
    .lvl     (sync_q),
    .cfg_sel (cfg_sel),
    .cfg_pol (cfg_pol),
    .src_lvl (src_lvl),
    .xint    (xint)
  );

  assign wake_req = |(wake_q & sync_q);

  // Read path
  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (idx == IDX_W'(w)) begin
        if (region == RG_DATA) bus_rdata = sync_q[w*DW +: DW];
        if (region == RG_DIR)  bus_rdata = dir_q[w*DW +: DW];
        if (region == RG_WAKE) bus_rdata = wake_q[w*DW +: DW];
        if (region[REG_W-1])   bus_rdata = latch_q[w*DW +: DW];
      end
    end
    for (int m = 0; m < NMUXW; m++) begin
      if (region == RG_MUX && idx == IDX_W'(m)) bus_rdata = mux_q[m*DW +: DW];
    end
    for (int c = 0; c < NXINT; c++) begin
      if (region == RG_XINT && idx == IDX_W'(c)) begin
        bus_rdata              = DW'(cfg_sel[c*SELW +: SELW]);
        bus_rdata[POL_BIT]     = cfg_pol[c];
      end
    end
  end

endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 64,
  parameter int DW      = 32,
  parameter int NXINT   = 3,
  parameter int CFG_DLY = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [NPINS-1:0]   pin_in,
  input logic [NPINS-1:0]   sync_q,
  input logic [NPINS-1:0]   latch_q,
  input logic [2*NPINS-1:0] mux_q,
  input logic [2*NPINS-1:0] mux_live,
  input logic [NXINT-1:0]   xint
);

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  logic [2*NPINS-1:0] shadow [CFG_DLY];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_DLY; i++) shadow[i] <= '0;
    end else begin
      shadow[0] <= mux_q;
      for (int i = 1; i < CFG_DLY; i++) shadow[i] <= shadow[i-1];
    end
  end

  logic op_w0;
  assign op_w0 = bus_we && bus_addr[ADDR_W-1] && bus_addr[IDX_W-1:0] == '0;

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_w0 && bus_addr[IDX_W] && !bus_addr[IDX_W+1]
    |=> (latch_q[DW-1:0] & $past(bus_wdata)) == $past(bus_wdata));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_w0 && bus_addr[IDX_W+1]
    |=> (latch_q[DW-1:0] & $past(bus_wdata)) == '0);

  // R4
  untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_w0
    |=> (latch_q[DW-1:0] & ~$past(bus_wdata)) == ($past(latch_q[DW-1:0]) & ~$past(bus_wdata)));

  // R8
  mux_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_live == shadow[CFG_DLY-1]);

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q >= 2'd2 |-> sync_q == $past(pin_in, 2));

  for (genvar c = 0; c < NXINT; c++) begin : g_x
    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xint[c] |=> !xint[c]);
  end

endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
  .NPINS(NPINS), .DW(DW), .NXINT(NXINT), .CFG_DLY(CFG_DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_in(pin_in), .sync_q(sync_q),
  .latch_q(latch_q), .mux_q(mux_q), .mux_live(mux_live), .xint(xint)
);

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [3*NP-1:0] per_out = '0;
  logic [3*NP-1:0] per_oe = '0;
  logic [2:0]    xint;
  logic          wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .per_out(per_out), .per_oe(per_oe),
    .xint(xint), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ad(input int rg, input int ix);
    return {4'(rg), 2'(ix)};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pin_oe", 64'(pin_oe), 64'h0);
    check("R1 pin_out", 64'(pin_out), 64'h0);
    check("R1 xint/wake", {60'h0, xint, wake_req}, 64'h0);
    rd(ad(8, 0), d); check("R1 latch w0", 64'(d), 64'h0);
    rd(ad(8, 1), d); check("R1 latch w1", 64'(d), 64'h0);
    rd(ad(1, 0), d); check("R1 dir w0", 64'(d), 64'h0);
    rd(ad(3, 3), d); check("R1 mux w3", 64'(d), 64'h0);
  endtask

  task automatic t_latch_ops;
    logic [31:0] d;
    wr(ad(0, 0), 32'h0000_FFFF);
    rd(ad(8, 0), d); check("R3 direct load", 64'(d), 64'h0000_FFFF);
    rd(ad(12, 0), d); check("R3 readback any op region", 64'(d), 64'h0000_FFFF);
    wr(ad(9, 0), 32'h00FF_0000);
    rd(ad(8, 0), d); check("R4 set", 64'(d), 64'h00FF_FFFF);
    wr(ad(10, 0), 32'h0000_000F);
    rd(ad(8, 0), d); check("R4 clear", 64'(d), 64'h00FF_FFF0);
    wr(ad(12, 0), 32'hF000_00F0);
    rd(ad(8, 0), d); check("R4 toggle", 64'(d), 64'hF0FF_FF00);
    wr(ad(8, 0), 32'hFFFF_FFFF);
    rd(ad(8, 0), d); check("R4 region 8 no-op", 64'(d), 64'hF0FF_FF00);
    rd(ad(8, 1), d); check("R4 other word untouched", 64'(d), 64'h0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(ad(15, 0), 32'h0000_0F00);
    rd(ad(8, 0), d); check("R5 clear over set and toggle", 64'(d), 64'hF0FF_F000);
    wr(ad(13, 0), 32'h0000_F000);
    rd(ad(8, 0), d); check("R5 set over toggle", 64'(d), 64'hF0FF_F000);
    wr(ad(14, 0), 32'h0000_000F);
    rd(ad(8, 0), d); check("R5 clear over toggle", 64'(d), 64'hF0FF_F000);
    wr(ad(11, 0), 32'hF000_0000);
    rd(ad(8, 0), d); check("R5 clear over set", 64'(d), 64'h00FF_F000);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    check("R6 input holds, no drive", 64'(pin_oe[31:0]), 64'h0);
    wr(ad(1, 0), 32'hFFFF_FFFF);
    check("R6 oe after dir write", 64'(pin_oe[31:0]), 64'hFFFF_FFFF);
    check("R6 drives loaded latch", 64'(pin_out[31:0]), 64'h00FF_F000);
    rd(ad(1, 0), d); check("R6 dir readback", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk);
    pin_in[63:32] = 32'hA5A5_0F0F;
    pin_in[31:0]  = 32'h1234_5678;
    @(negedge clk);
    rd(ad(0, 1), d); check("R2 not after one edge", 64'(d), 64'h0);
    @(negedge clk);
    rd(ad(0, 1), d); check("R2 after two edges", 64'(d), 64'hA5A5_0F0F);
    rd(ad(0, 0), d); check("R2 pad level on output pins", 64'(d), 64'h1234_5678);
    pin_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mux;
    logic [31:0] d;
    wr(ad(0, 0), 32'h0);
    per_out[NP+0] = 1'b1;   per_oe[NP+0] = 1'b0;
    per_out[3] = 1'b1;      per_oe[3] = 1'b0;
    per_out[2*NP+17] = 1'b1; per_oe[2*NP+17] = 1'b1;
    bus_we = 1'b1; bus_addr = ad(3, 0); bus_wdata = 32'h0000_0042;
    @(negedge clk);
    bus_addr = ad(3, 1); bus_wdata = 32'h0000_000C;
    @(negedge clk);
    bus_we = 1'b0;
    rd(ad(3, 0), d); check("R8 immediate readback", 64'(d), 64'h42);
    check("R8 old routing after write edge", {62'h0, pin_out[0], pin_oe[0]}, 64'h1);
    @(negedge clk);
    check("R8 new routing two edges after", {62'h0, pin_out[0], pin_oe[0]}, 64'h2);
    check("R7 alt1 pin3", {62'h0, pin_out[3], pin_oe[3]}, 64'h2);
    check("R8 pin17 still old one edge after", {62'h0, pin_out[17], pin_oe[17]}, 64'h1);
    @(negedge clk);
    check("R7 alt3 pin17", {62'h0, pin_out[17], pin_oe[17]}, 64'h3);
    check("R7 pin1 stays gpio", {62'h0, pin_out[1], pin_oe[1]}, 64'h1);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    wr(ad(2, 1), 32'h0000_0100);
    rd(ad(2, 1), d); check("R11 mask readback", 64'(d), 64'h100);
    @(negedge clk); pin_in[41] = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 unmasked pin no wake", 64'(wake_req), 64'h0);
    pin_in[40] = 1'b1;
    @(negedge clk);
    check("R11 not before sync", 64'(wake_req), 64'h0);
    @(negedge clk);
    check("R11 masked pin wakes", 64'(wake_req), 64'h1);
  endtask

  task automatic t_xint;
    logic [31:0] d;
    wr(ad(4, 0), 32'h0000_0129);
    rd(ad(4, 0), d); check("R9 config readback", 64'(d), 64'h129);
    check("R10 no pulse on reselect", 64'(xint), 64'h0);
    @(negedge clk);
    check("R10 no pulse next cycle", 64'(xint), 64'h0);
    wr(ad(4, 1), 32'h0000_0128);
    pin_in[40] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 falling ignored by rising ch", 64'(xint), 64'h0);
    pin_in[40] = 1'b1;
    @(negedge clk);
    check("R9 no pulse one edge after", 64'(xint), 64'h0);
    @(negedge clk);
    check("R9 rising pulse", 64'(xint), 64'h2);
    @(negedge clk);
    check("R9 pulse one cycle", 64'(xint), 64'h0);
    wr(ad(4, 1), 32'h0000_0028);
    pin_in[40] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 falling pulse", 64'(xint), 64'h2);
    @(negedge clk);
    check("R9 falling pulse ends", 64'(xint), 64'h0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_ops();
    t_priority();
    t_direction();
    t_sync();
    t_mux();
    t_wake();
    t_xint();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule